// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit with Status Flags

This block holds an 8-bit accumulator together with the arithmetic status flags of a small processor: carry, nibble (auxiliary) carry and signed overflow. It also produces an even-parity bit. Each cycle in which `op_valid` is high, the unit applies one operation from `op_code` to the accumulator. The operations are: load the operand, add, add with carry, subtract with borrow, and two one-bit logic operations that use the carry flag as a Boolean accumulator.

The parity output always follows the accumulator that is currently held. It is not tied to any operation. The other flags change only when an operation that defines them is applied. Instruction decode, multiply, divide and decimal adjust are the job of the surrounding core.

Top module: `acc_flag_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator, carry, auxiliary carry and overflow all become 0. The parity output is then 0.
- R2: Add (code 2) stores (acc + operand) mod 256 in the accumulator. It sets carry to the carry out of bit 7 and leaves it clear otherwise. Example: FFh + 01h gives 00h with carry 1.
- R3: After add, add-with-carry or subtract-with-borrow, the auxiliary carry holds the carry from bit 3 into bit 4, or the borrow out of bit 3 for a subtraction. Example: 38h + 2Fh gives 67h with aux carry 1 and carry 0. Example: 88h + 93h gives 1Bh with aux carry 0 and carry 1.
- R4: After add, add-with-carry or subtract-with-borrow, overflow is 1 exactly when the signed two's-complement result does not fit in 8 bits. Example: 0Fh + 7Fh gives 8Eh with overflow 1.
- R5: Add-with-carry (code 3) stores acc + operand + carry and updates all three arithmetic flags.
- R6: Subtract-with-borrow (code 4) stores acc − operand − carry. Carry is then 1 exactly when the true difference is negative.
- R7: The parity output is set so that the number of ones in the accumulator plus the parity bit is even, and it tracks every change of the accumulator. Example: accumulator 10101101b gives parity 1.
- R8: Load (code 1) copies the operand into the accumulator and leaves carry, aux carry and overflow unchanged.
- R9: Carry-AND (code 5) replaces carry with carry AND `bit_in`. The accumulator, aux carry and overflow do not change.
- R10: Carry-OR (code 6) replaces carry with carry OR `bit_in`. The accumulator, aux carry and overflow do not change.
- R11: With `op_valid` low, or with code 0 or code 7, the accumulator and all three flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Applies `op_code` in this cycle |
| op_code | input | 3 | Operation select (0 none, 1 load, 2 add, 3 add with carry, 4 subtract with borrow, 5 carry AND, 6 carry OR, 7 none) |
| operand | input | 8 | Second arithmetic operand, or the load value |
| bit_in | input | 1 | Single bit for the carry logic operations |
| acc | output | 8 | Accumulator |
| cy | output | 1 | Carry / borrow flag, also the Boolean accumulator |
| ac | output | 1 | Auxiliary (nibble) carry flag |
| ov | output | 1 | Signed overflow flag |
| par | output | 1 | Even-parity bit of the accumulator |

## Verification
The assertions assume that `op_code`, `operand` and `bit_in` hold steady from one falling edge to the next, and that they carry known values whenever `op_valid` is high. Codes 0 and 7 are the only ones given no effect. The stimulus drives every input at the falling edge only, and it never leaves the operand undefined. It exercises the reserved codes and `op_valid` low with arithmetic codes present, so that the hold properties are tested. Operand values come from fixed corner cases and a linear-feedback sequence, which keeps the operands in the defined 8-bit range.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int ACC_W = 8;
    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_ADD  = 3'd2,
        OP_ADDC = 3'd3,
        OP_SUBB = 3'd4,
        OP_ANDC = 3'd5,
        OP_ORC  = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } flags_t;

    function automatic logic is_arith(op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

    function automatic logic uses_carry_in(op_e op);
        return (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
    parameter int DATA_W = acc_pkg::ACC_W,
    parameter int LOW_W  = acc_pkg::NIB_W
) (
    input  logic              [DATA_W-1:0] a,
    input  logic              [DATA_W-1:0] b,
    input  logic                           sub,
    input  logic                           cin,
    output logic              [DATA_W-1:0] result,
    output acc_pkg::flags_t                flags
);
    localparam int TOP_W = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              c0;
    logic [LOW_W:0]    low_sum;
    logic [TOP_W:0]    top_sum;
    logic [DATA_W:0]   full_sum;
    logic              c_into_msb;
    logic              c_out;

    always_comb begin
        b_eff      = sub ? ~b : b;
        c0         = sub ? ~cin : cin;
        low_sum    = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, c0};
        top_sum    = {1'b0, a[TOP_W-1:0]} + {1'b0, b_eff[TOP_W-1:0]} + {{TOP_W{1'b0}}, c0};
        full_sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};
        c_into_msb = top_sum[TOP_W];
        c_out      = full_sum[DATA_W];
        result     = full_sum[DATA_W-1:0];
        flags.cy   = sub ? ~c_out : c_out;
        flags.ac   = sub ? ~low_sum[LOW_W] : low_sum[LOW_W];
        flags.ov   = c_into_msb ^ c_out;
    end
endmodule

// File: rtl/acc_parity.sv
module acc_parity #(
    parameter int DATA_W = acc_pkg::ACC_W
) (
    input  logic [DATA_W-1:0] d,
    output logic              p
);
    logic [DATA_W:0] chain;
    assign chain[0] = 1'b0;
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_xor
        assign chain[gi+1] = chain[gi] ^ d[gi];
    end
    assign p = chain[DATA_W];
endmodule

// File: rtl/acc_carry_logic.sv
module acc_carry_logic (
    input  logic cy_now,
    input  logic bit_in,
    input  logic use_or,
    output logic cy_next
);
    always_comb begin
        cy_next = use_or ? (cy_now | bit_in) : (cy_now & bit_in);
    end
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit #(
    parameter int DATA_W = acc_pkg::ACC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    input  logic              bit_in,
    output logic [DATA_W-1:0] acc,
    output logic              cy,
    output logic              ac,
    output logic              ov,
    output logic              par
);
    import acc_pkg::*;

    op_e               op;
    logic [DATA_W-1:0] acc_q;
    flags_t            flg_q;
    logic [DATA_W-1:0] sum_res;
    flags_t            sum_flg;
    logic              cy_logic;

    assign op = op_e'(op_code);

    acc_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (acc_q),
        .b      (operand),
        .sub    (op == OP_SUBB),
        .cin    (uses_carry_in(op) ? flg_q.cy : 1'b0),
        .result (sum_res),
        .flags  (sum_flg)
    );

    acc_carry_logic u_cylogic (
        .cy_now  (flg_q.cy),
        .bit_in  (bit_in),
        .use_or  (op == OP_ORC),
        .cy_next (cy_logic)
    );

    acc_parity #(.DATA_W(DATA_W)) u_par (
        .d (acc_q),
        .p (par)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            flg_q <= '0;
        end else if (op_valid) begin
            unique case (op)
                OP_LOAD: acc_q <= operand;
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    acc_q <= sum_res;
                    flg_q <= sum_flg;
                end
                OP_ANDC, OP_ORC: flg_q.cy <= cy_logic;
                default: ;
            endcase
        end
    end

    assign acc = acc_q;
    assign cy  = flg_q.cy;
    assign ac  = flg_q.ac;
    assign ov  = flg_q.ov;

    // R1: reset state
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc == '0) && !cy && !ac && !ov);

    // R7: even parity over accumulator plus parity bit
    a_r7_even_parity: assert property (@(posedge clk) disable iff (rst)
        (($countones(acc) + int'(par)) % 2) == 0);

    // R2: plain add result and carry
    a_r2_add_sum: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd2) |=>
        ({cy, acc} == ({1'b0, $past(acc)} + {1'b0, $past(operand)})));

    // R8: load keeps flags
    a_r8_load_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1) |=>
        (acc == $past(operand)) && $stable({cy, ac, ov}));

    // R9: carry AND
    a_r9_carry_and: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd5) |=>
        (cy == ($past(cy) & $past(bit_in))) && $stable({acc, ac, ov}));

    // R10: carry OR
    a_r10_carry_or: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd6) |=>
        (cy == ($past(cy) | $past(bit_in))) && $stable({acc, ac, ov}));

    // R11: idle or reserved codes hold all state
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code == 3'd0 || op_code == 3'd7) |=>
        $stable({acc, cy, ac, ov}));
endmodule

// File: tb/test_acc_flag_unit.sv
module test_acc_flag_unit;
    localparam int CLK_P = 10;

    typedef struct {
        logic [7:0] acc;
        logic       cy;
        logic       ac;
        logic       ov;
        logic       par;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [2:0] op_code;
    logic [7:0] operand;
    logic       bit_in;
    logic [7:0] acc;
    logic       cy, ac, ov, par;

    int n_checks = 0;
    int n_errors = 0;
    exp_t q[$];

    logic [7:0] m_acc;
    logic       m_cy, m_ac, m_ov;

    always #(CLK_P/2) clk = ~clk;

    acc_flag_unit i_acc_flag_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .bit_in(bit_in),
        .acc(acc), .cy(cy), .ac(ac), .ov(ov), .par(par)
    );

    function automatic logic even_par(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return (n % 2) == 1;
    endfunction

    function automatic int sval(logic [7:0] v);
        return (v > 8'd127) ? int'(v) - 256 : int'(v);
    endfunction

    task automatic compare(exp_t e);
        n_checks++;
        if (acc !== e.acc || cy !== e.cy || ac !== e.ac || ov !== e.ov || par !== e.par) begin
            n_errors++;
            $display("FAIL %s: actual acc=%h cy=%b ac=%b ov=%b p=%b expected acc=%h cy=%b ac=%b ov=%b p=%b",
                     e.tag, acc, cy, ac, ov, par, e.acc, e.cy, e.ac, e.ov, e.par);
        end
    endtask

    // Reference model and driver
    task automatic do_op(logic v, logic [2:0] code, logic [7:0] opd, logic b, string tag);
        int a_i, b_i, c_i, r, lo, sr;
        exp_t e;
        @(negedge clk);
        op_valid = v; op_code = code; operand = opd; bit_in = b;
        if (v) begin
            a_i = int'(m_acc); b_i = int'(opd);
            c_i = (code == 3'd3 || code == 3'd4) ? int'(m_cy) : 0;
            case (code)
                3'd1: m_acc = opd;
                3'd2, 3'd3: begin
                    r  = a_i + b_i + c_i;
                    lo = (a_i % 16) + (b_i % 16) + c_i;
                    sr = sval(m_acc) + sval(opd) + c_i;
                    m_acc = r[7:0]; m_cy = r > 255; m_ac = lo > 15;
                    m_ov = (sr > 127) || (sr < -128);
                end
                3'd4: begin
                    r  = a_i - b_i - c_i;
                    lo = (a_i % 16) - (b_i % 16) - c_i;
                    sr = sval(m_acc) - sval(opd) - c_i;
                    m_acc = r[7:0]; m_cy = r < 0; m_ac = lo < 0;
                    m_ov = (sr > 127) || (sr < -128);
                end
                3'd5: m_cy = m_cy & b;
                3'd6: m_cy = m_cy | b;
                default: ;
            endcase
        end
        e.acc = m_acc; e.cy = m_cy; e.ac = m_ac; e.ov = m_ov;
        e.par = even_par(m_acc); e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] lf;
        rst = 1'b1; op_valid = 1'b0; op_code = 3'd0; operand = 8'h00; bit_in = 1'b0;
        m_acc = 8'h00; m_cy = 1'b0; m_ac = 1'b0; m_ov = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_checks++;
        if (acc !== 8'h00 || cy !== 1'b0 || ac !== 1'b0 || ov !== 1'b0 || par !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: actual acc=%h cy=%b ac=%b ov=%b p=%b expected all zero", acc, cy, ac, ov, par);
        end

        do_op(1, 3'd1, 8'hFF, 0, "R8 load FF");
        do_op(1, 3'd2, 8'h01, 0, "R2 FF+01");
        do_op(1, 3'd1, 8'h0F, 0, "R8 load keeps flags");
        do_op(1, 3'd2, 8'h7F, 0, "R4 0F+7F overflow");
        do_op(1, 3'd1, 8'h38, 0, "R8 load 38");
        do_op(1, 3'd2, 8'h2F, 0, "R3 38+2F aux carry");
        do_op(1, 3'd1, 8'h9C, 0, "R8 load 9C");
        do_op(1, 3'd2, 8'h64, 0, "R2 9C+64");
        do_op(1, 3'd1, 8'h88, 0, "R8 load 88");
        do_op(1, 3'd2, 8'h93, 0, "R3 88+93 no aux");
        do_op(1, 3'd3, 8'h05, 0, "R5 addc with carry set");
        do_op(1, 3'd3, 8'h01, 0, "R5 addc carry clear");
        do_op(1, 3'd1, 8'h00, 0, "R8 load 00");
        do_op(1, 3'd4, 8'h01, 0, "R6 subb borrow out");
        do_op(1, 3'd4, 8'h00, 0, "R6 subb borrow in");
        do_op(1, 3'd1, 8'h80, 0, "R8 load 80");
        do_op(1, 3'd4, 8'h01, 0, "R6 subb signed overflow");
        do_op(1, 3'd1, 8'hAD, 0, "R7 parity of AD");
        do_op(1, 3'd6, 8'h00, 1, "R10 carry or 1");
        do_op(1, 3'd5, 8'h00, 1, "R9 carry and 1");
        do_op(1, 3'd5, 8'h00, 0, "R9 carry and 0");
        do_op(1, 3'd6, 8'h00, 0, "R10 carry or 0");
        do_op(0, 3'd2, 8'h55, 1, "R11 valid low with add");
        do_op(1, 3'd7, 8'h55, 1, "R11 reserved code");
        do_op(1, 3'd0, 8'h55, 1, "R11 nop code");

        lf = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            c = 3'(i % 8);
            do_op((i % 11) != 3, c, lf, lf[0],
                  (c == 3'd4) ? "R6 sweep" : (c == 3'd3) ? "R5 sweep" :
                  (c == 3'd2) ? "R4 sweep" : (c == 3'd1) ? "R7 sweep" :
                  (c == 3'd5) ? "R9 sweep" : (c == 3'd6) ? "R10 sweep" : "R11 sweep");
        end

        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(posedge clk);
        #(CLK_P/2);
        finish_run();
    end
endmodule